// File: doc/BRIEF.md
# SCSI Auto Status Command Sequencer

This block holds the SCSI mode bits and runs a small hardware sequencer. The sequencer issues the closing commands of a SCSI transaction to a separate phase engine, so the CPU does not have to. The CPU starts a data transfer by writing a command code into the command register. Without an automatic mode, the command goes to the phase engine and the block returns to idle once the engine acknowledges it.

With an automatic mode selected, a completed DMA data command (plain DMA or FIFO-DMA, either direction) triggers further commands:
- **Full mode** issues status-and-message, then bus free, then wait-for-selection-and-command.
- **Status-only mode** issues only status-and-message.

Each step waits for the phase engine's acknowledge before the next step goes out. When a sequence ends, a sticky completion interrupt is raised. While a sequence runs, the status register shows the auto and busy flags as set, and the command register reads back the step in progress.

The mode register also holds enables for the data path and the handshake drivers. The ultra enable is passed on only when the synchronous rate field allows it.

Top module: `scsi_autoseq`

## Requirements
- R1: The mode register at offset 0x29 stores bits 4:0 and reads 0 in bits 7:5. Bit 1 drives `an_reqack_en` and bit 0 drives `an_data_en`.
- R2: `ultra_en` is 1 only when mode bit 4 is 1 and the rate field (offset 0x2C, bits 2:0) is 0 or 1. Any other rate value gives 0.
- R3: A CPU write to the command register (offset 0x2A) while the block is idle produces a `cmd_valid` pulse one cycle long, carrying the written code, in the cycle after the write. The busy flag (offset 0x2B, bit 0) then reads 1 until `cmd_done` arrives.
- R4: Data command codes are 0x10, 0x11, 0x12 and 0x13. With mode bit 3 set, finishing a data command issues 0x20 (status-and-message), then 0x21 (bus free), then 0x22 (wait-for-selection). Each code goes out only after `cmd_done` for the previous one.
- R5: With only mode bit 2 set, finishing a data command issues 0x20 alone, and the block then returns to idle.
- R6: With both bit 3 and bit 2 set, the full three-step sequence runs.
- R7: The completion flag (offset 0x2D, bit 0, mirrored on `irq`):
  - It sets on the `cmd_done` of the last step of a sequence.
  - It stays set until the CPU writes 1 to that bit; writing 0 leaves it unchanged.
  - A non-data command, or any command issued with no auto bit set, never sets it.
- R8: While a sequence runs, offset 0x2B reads 1 in bit 1 (auto) and in bit 0 (busy), and the command register reads the code being issued. Once the block is idle again, the command register reads the last value the CPU wrote.
- R9: A CPU write to the command register while a command or sequence is in progress produces no `cmd_valid` and does not change the value read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | CPU register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| cmd_valid | output | 1 | One-cycle command strobe to the phase engine |
| cmd_code | output | 8 | Command code for the phase engine |
| cmd_done | input | 1 | Command-finished pulse from the phase engine |
| irq | output | 1 | Sticky sequence-complete interrupt |
| ultra_en | output | 1 | Qualified ultra transfer enable |
| an_reqack_en | output | 1 | Active negation enable, handshake lines |
| an_data_en | output | 1 | Active negation enable, data and parity lines |

## Verification
The bench builds the block with its default parameters: an 8-bit register bus and a 3-bit rate field. With these, every rate value from 0 to 7 can be swept against the ultra qualification. All four data command codes fit in the command register, so both plain DMA and FIFO-DMA triggers are reached. A scoreboard predicts the exact order of command codes for full, status-only, combined-bit and no-auto runs, and reports any strobe it did not expect.

// File: rtl/scsi_autoseq_pkg.sv
// Package: shared command codes, register offsets and helpers for the
// auto status sequencer. Assumes 8-bit command codes.
package scsi_autoseq_pkg;

    localparam logic [7:0] CMD_DMA_IN       = 8'h10;
    localparam logic [7:0] CMD_DMA_OUT      = 8'h11;
    localparam logic [7:0] CMD_FIFO_DMA_IN  = 8'h12;
    localparam logic [7:0] CMD_FIFO_DMA_OUT = 8'h13;
    localparam logic [7:0] CMD_STS_MSG      = 8'h20;
    localparam logic [7:0] CMD_BUS_FREE     = 8'h21;
    localparam logic [7:0] CMD_WAIT_SEL     = 8'h22;

    localparam logic [7:0] OFS_MODE = 8'h29;
    localparam logic [7:0] OFS_CMD  = 8'h2A;
    localparam logic [7:0] OFS_CTL  = 8'h2B;
    localparam logic [7:0] OFS_RATE = 8'h2C;
    localparam logic [7:0] OFS_IRQ  = 8'h2D;

    // Sequencer states: idle, CPU command pending, and one state per auto step
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CPU,
        ST_STS,
        ST_BFREE,
        ST_WSEL
    } seq_state_t;

    // True for any DMA data command (plain or FIFO, either direction)
    function automatic logic is_data_cmd(input logic [7:0] code);
        return (code == CMD_DMA_IN) || (code == CMD_DMA_OUT) ||
               (code == CMD_FIFO_DMA_IN) || (code == CMD_FIFO_DMA_OUT);
    endfunction

endpackage

// File: rtl/scsi_autoseq_fsm.sv
// Module: command sequencer. Forwards CPU commands to the phase engine and,
// after a data command finishes with an auto mode set, chains the status,
// bus-free and wait-for-selection steps. Assumes cmd_done is a one-cycle
// pulse that never arrives in the same cycle as cmd_valid.
module scsi_autoseq_fsm
    import scsi_autoseq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [CW-1:0] cmd_wdata,
    input  logic          cmd_done,
    input  logic          auto_full,
    input  logic          auto_sts,
    output logic          cmd_valid,
    output logic [CW-1:0] cmd_code,
    output logic          seq_idle,
    output logic          seq_running,
    output logic          irq_set
);

    seq_state_t state_q;
    logic       data_q;
    logic       full_q;

    // Step the sequencer and launch each command strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            data_q    <= 1'b0;
            full_q    <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (cmd_wr) begin
                    state_q   <= ST_CPU;
                    cmd_valid <= 1'b1;
                    cmd_code  <= cmd_wdata;
                    data_q    <= is_data_cmd(cmd_wdata);
                end
                ST_CPU: if (cmd_done) begin
                    if (data_q && (auto_full || auto_sts)) begin
                        state_q   <= ST_STS;
                        cmd_valid <= 1'b1;
                        cmd_code  <= CMD_STS_MSG;
                        full_q    <= auto_full;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_STS: if (cmd_done) begin
                    if (full_q) begin
                        state_q   <= ST_BFREE;
                        cmd_valid <= 1'b1;
                        cmd_code  <= CMD_BUS_FREE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_BFREE: if (cmd_done) begin
                    state_q   <= ST_WSEL;
                    cmd_valid <= 1'b1;
                    cmd_code  <= CMD_WAIT_SEL;
                end
                ST_WSEL: if (cmd_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode status views and the end-of-sequence event
    always_comb begin
        seq_idle    = (state_q == ST_IDLE);
        seq_running = (state_q == ST_STS) || (state_q == ST_BFREE) ||
                      (state_q == ST_WSEL);
        irq_set     = cmd_done && (((state_q == ST_STS) && !full_q) ||
                                   (state_q == ST_WSEL));
    end

endmodule

// File: rtl/scsi_autoseq_regs.sv
// Module: CPU-visible register file: mode, command, control/status, rate and
// interrupt registers, plus the read mux. Assumes single-cycle writes and a
// combinational read path.
module scsi_autoseq_regs
    import scsi_autoseq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    input  logic              seq_idle,
    input  logic              seq_running,
    input  logic              irq_set,
    input  logic [DW-1:0]     cur_code,
    output logic              cmd_wr,
    output logic [4:0]        mode_q,
    output logic [RATE_W-1:0] rate_q,
    output logic              irq_q
);

    localparam int PAD_MODE = DW - 5;
    localparam int PAD_RATE = DW - RATE_W;

    logic [DW-1:0] cpu_cmd_q;
    logic          auto_sw_q;

    // Accept command writes only while nothing is in progress
    always_comb cmd_wr = cpu_we && (cpu_addr == AW'(OFS_CMD)) && seq_idle;

    // Hold the writable register contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            rate_q    <= '0;
            cpu_cmd_q <= '0;
            auto_sw_q <= 1'b0;
        end else if (cpu_we) begin
            if (cpu_addr == AW'(OFS_MODE)) mode_q    <= cpu_wdata[4:0];
            if (cpu_addr == AW'(OFS_RATE)) rate_q    <= cpu_wdata[RATE_W-1:0];
            if (cpu_addr == AW'(OFS_CTL))  auto_sw_q <= cpu_wdata[1];
            if (cmd_wr)                    cpu_cmd_q <= cpu_wdata;
        end
    end

    // Sticky completion flag: set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (irq_set)
            irq_q <= 1'b1;
        else if (cpu_we && (cpu_addr == AW'(OFS_IRQ)) && cpu_wdata[0])
            irq_q <= 1'b0;
    end

    // Read mux; status bits and command view follow the sequencer
    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            AW'(OFS_MODE): cpu_rdata = {{PAD_MODE{1'b0}}, mode_q};
            AW'(OFS_CMD):  cpu_rdata = seq_running ? cur_code : cpu_cmd_q;
            AW'(OFS_CTL):  cpu_rdata = {{(DW-2){1'b0}},
                                        auto_sw_q | seq_running, !seq_idle};
            AW'(OFS_RATE): cpu_rdata = {{PAD_RATE{1'b0}}, rate_q};
            AW'(OFS_IRQ):  cpu_rdata = {{(DW-1){1'b0}}, irq_q};
            default:       cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/scsi_autoseq.sv
// Module: top of the auto status sequencer. Joins the register file and the
// sequencer and qualifies the ultra enable with the rate field. Assumes an
// 8-bit register bus so the mode register map fits.
module scsi_autoseq
    import scsi_autoseq_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 8,
    parameter int RATE_W    = 3,
    parameter int ULTRA_MAX = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_code,
    input  logic          cmd_done,
    output logic          irq,
    output logic          ultra_en,
    output logic          an_reqack_en,
    output logic          an_data_en
);

    logic              cmd_wr;
    logic              seq_idle;
    logic              seq_running;
    logic              irq_set;
    logic [4:0]        mode_q;
    logic [RATE_W-1:0] rate_q;

    scsi_autoseq_regs #(.DW(DW), .AW(AW), .RATE_W(RATE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .seq_idle    (seq_idle),
        .seq_running (seq_running),
        .irq_set     (irq_set),
        .cur_code    (cmd_code),
        .cmd_wr      (cmd_wr),
        .mode_q      (mode_q),
        .rate_q      (rate_q),
        .irq_q       (irq)
    );

    scsi_autoseq_fsm #(.CW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_wdata   (cpu_wdata),
        .cmd_done    (cmd_done),
        .auto_full   (mode_q[3]),
        .auto_sts    (mode_q[2]),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .seq_idle    (seq_idle),
        .seq_running (seq_running),
        .irq_set     (irq_set)
    );

    // Drive the held enables; ultra only with an allowed rate
    always_comb begin
        ultra_en     = mode_q[4] && (int'(rate_q) <= ULTRA_MAX);
        an_reqack_en = mode_q[1];
        an_data_en   = mode_q[0];
    end

endmodule

// File: rtl/scsi_autoseq_chk.sv
// Module: assertion checker for the auto status sequencer, attached by bind.
module scsi_autoseq_chk
    import scsi_autoseq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [DW-1:0] cmd_code,
    input logic          cmd_done,
    input logic          irq,
    input logic          seq_running
);

    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_done));

    // R4
    auto_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seq_running) |->
        (cmd_code == CMD_STS_MSG || cmd_code == CMD_BUS_FREE ||
         cmd_code == CMD_WAIT_SEL));

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_running && !cmd_done) |=> $stable(cmd_code));

endmodule

bind scsi_autoseq scsi_autoseq_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_done    (cmd_done),
    .irq         (irq),
    .seq_running (seq_running)
);

// File: tb/scsi_autoseq_tb_top.sv
`timescale 1ns/1ps
module scsi_autoseq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cmd_valid;
    logic [7:0] cmd_code;
    logic       cmd_done = 1'b0;
    logic       irq, ultra_en, an_reqack_en, an_data_en;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    scsi_autoseq dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_done(cmd_done), .irq(irq),
        .ultra_en(ultra_en), .an_reqack_en(an_reqack_en),
        .an_data_en(an_data_en)
    );

    task automatic chk(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [7:0] code, input string req);
        exp_q.push_back(code);
        req_q.push_back(req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp,
                          input string req);
        @(negedge clk);
        cpu_addr = a;
        #1 chk(req, cpu_rdata, exp);
    endtask

    task automatic done_pulse();
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the scoreboard on every command strobe
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9: actual unexpected strobe %h expected none",
                         cmd_code);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                if (cmd_code !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", r, cmd_code, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        rd_chk(8'h29, 8'h00, "R1 reset");
        rd_chk(8'h2B, 8'h00, "R3 reset busy");
        chk("R7 reset irq", {7'b0, irq}, 8'h00);

        // R1 mode bits and unused bits
        wr(8'h29, 8'hE3);
        rd_chk(8'h29, 8'h03, "R1 mode readback");
        chk("R1 an_reqack", {7'b0, an_reqack_en}, 8'h01);
        chk("R1 an_data", {7'b0, an_data_en}, 8'h01);

        // R2 ultra qualification across all rates
        wr(8'h29, 8'h10);
        for (int r = 0; r < 8; r++) begin
            wr(8'h2C, 8'(r));
            chk("R2 ultra", {7'b0, ultra_en}, (r <= 1) ? 8'h01 : 8'h00);
        end
        wr(8'h29, 8'h00);
        chk("R2 ultra off", {7'b0, ultra_en}, 8'h00);

        // R3 no auto: single command only
        expect_cmd(8'h10, "R3");
        wr(8'h2A, 8'h10);
        rd_chk(8'h2B, 8'h01, "R3 busy");
        done_pulse();
        idle(4);
        rd_chk(8'h2B, 8'h00, "R3 idle");
        chk("R7 no auto irq", {7'b0, irq}, 8'h00);

        // R4 full mode with R8/R9 checks during the run
        wr(8'h29, 8'h08);
        wr(8'h2B, 8'h00);
        expect_cmd(8'h11, "R4 data");
        wr(8'h2A, 8'h11);
        idle(2);
        expect_cmd(8'h20, "R4 sts");
        done_pulse();
        rd_chk(8'h2B, 8'h03, "R8 flags");
        rd_chk(8'h2A, 8'h20, "R8 cmd view");
        wr(8'h2A, 8'h05);
        idle(2);
        rd_chk(8'h2A, 8'h20, "R9 ignored");
        expect_cmd(8'h21, "R4 bfree");
        done_pulse();
        rd_chk(8'h2A, 8'h21, "R8 cmd view bfree");
        expect_cmd(8'h22, "R4 wsel");
        done_pulse();
        chk("R7 irq before end", {7'b0, irq}, 8'h00);
        done_pulse();
        idle(1);
        chk("R7 irq set", {7'b0, irq}, 8'h01);
        rd_chk(8'h2D, 8'h01, "R7 irq reg");
        rd_chk(8'h2B, 8'h00, "R8 flags clear");
        rd_chk(8'h2A, 8'h11, "R8 cpu value back");
        wr(8'h2D, 8'h00);
        chk("R7 write zero", {7'b0, irq}, 8'h01);
        wr(8'h2D, 8'h01);
        chk("R7 cleared", {7'b0, irq}, 8'h00);

        // R5 status-only with a FIFO-DMA trigger
        wr(8'h29, 8'h04);
        expect_cmd(8'h12, "R5 data");
        wr(8'h2A, 8'h12);
        expect_cmd(8'h20, "R5 sts");
        done_pulse();
        done_pulse();
        idle(6);
        chk("R5 irq", {7'b0, irq}, 8'h01);
        rd_chk(8'h2B, 8'h00, "R5 idle");
        chk("R5 nothing pending", 8'(exp_q.size()), 8'h00);
        wr(8'h2D, 8'h01);

        // R6 both bits: full sequence
        wr(8'h29, 8'h0C);
        expect_cmd(8'h13, "R6 data");
        wr(8'h2A, 8'h13);
        expect_cmd(8'h20, "R6 sts");
        done_pulse();
        expect_cmd(8'h21, "R6 bfree");
        done_pulse();
        expect_cmd(8'h22, "R6 wsel");
        done_pulse();
        done_pulse();
        idle(2);
        chk("R6 irq", {7'b0, irq}, 8'h01);
        wr(8'h2D, 8'h01);

        // R7 non-data command under full mode: no follow-up, no irq
        expect_cmd(8'h20, "R7 non-data");
        wr(8'h2A, 8'h20);
        done_pulse();
        idle(4);
        chk("R7 non-data irq", {7'b0, irq}, 8'h00);
        chk("R4 queue drained", 8'(exp_q.size()), 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule